// File: doc/BRIEF.md
# Boundary-Scan Data Register Path

This block sits behind a boundary-scan TAP. It holds the test data registers and routes the serial stream from TDI to the data-register output. The TAP state machine and the instruction register live outside the block. They supply the active 5-bit instruction and one strobe for each of the test-logic-reset, capture-DR, shift-DR and update-DR states. The falling-edge TDO multiplexer that follows this block is also outside it.

Three stages are present:

- a single-bit bypass stage;
- a 32-bit identification stage, which loads a fixed word built from parameters;
- a control stage with a parameterised width (64 bits by default) and a parallel hold register.

The hold register drives a control word into the chip. It keeps each value written at Update-DR until the TAP is reset. Every stage shifts toward the output, least significant bit first, on the rising edge of `tck` while shift-DR is active and the stage is selected.

Top module: `tap_dr_path`

## Requirements
- R1: Instruction `5'b00001` selects the identification stage and instruction `CTL_OP` (default `5'b01100`) selects the control stage. Every other code, including `5'b11111` and reserved codes such as `5'b10101`, selects the bypass stage.
- R2: A capture-DR cycle with the bypass stage selected clears that stage, so the first bit presented on `dr_tdo` after capture is 0, even when a 1 was shifted in before.
- R3: While the bypass stage is selected and shift-DR is active, `dr_tdo` presents the `tdi` value of the previous rising edge, which is a one-cycle delay.
- R4: A capture-DR cycle with the identification stage selected loads `{rev[3:0], design[5:0], part[9:0], maker[10:0], 1'b1}`. The default is `32'h0827401D`. Shift-DR then presents it on `dr_tdo` least significant bit first, so the first bit out is 1.
- R5: An update-DR cycle with the identification or bypass stage selected leaves `ctrl_word` unchanged. Each new capture reloads the same identification word.
- R6: With the control stage selected, `CTL_W` shift cycles move `tdi` in least significant bit first. An update-DR cycle then copies the shift stage onto `ctrl_word`, visible after that rising edge.
- R7: `ctrl_word` changes only on update-DR with the control stage selected, or on a reset. It does not change during shifts, captures or other instructions.
- R8: A capture-DR cycle with the control stage selected leaves its shift stage unchanged, so a following shift presents the previously shifted-in bits again.
- R9: `tap_rst` (synchronous, active high) or the `tlr` strobe clears both the control shift stage and `ctrl_word` to zero on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all stages update on its rising edge |
| tap_rst | input | 1 | Synchronous active-high TAP reset |
| tlr | input | 1 | TAP is in test-logic-reset |
| capture_dr | input | 1 | TAP is in capture-DR |
| shift_dr | input | 1 | TAP is in shift-DR |
| update_dr | input | 1 | TAP is in update-DR |
| ir_code | input | 5 | Active instruction code |
| tdi | input | 1 | Serial test data in |
| dr_tdo | output | 1 | Serial output of the selected stage, to the TDO multiplexer |
| ctrl_word | output | CTL_W | Parallel control word from the hold register |

## Verification
The bypass path is driven with a patterned bit stream that follows a shifted-in 1. This separates capture clearing from stale data and shows the exact one-cycle delay. The same stream under a reserved code confirms that the decode falls back to bypass.

The identification path is shifted out in full twice, with an update between the two passes. Any misplaced field, any reversed bit order or any missed reload shows up as a mismatch.

The control path is loaded with two different 64-bit words, each with no repeating pattern. A capture between the two loads must re-present the first word bit for bit. `ctrl_word` is checked after shifts, after updates under other instructions, and after each of the two reset sources.

// File: rtl/tap_dr_pkg.sv
package tap_dr_pkg;

    localparam int IR_W   = 5;
    localparam int ID_W   = 32;
    localparam int REV_W  = 4;
    localparam int DSG_W  = 6;
    localparam int PART_W = 10;
    localparam int MAKR_W = 11;

    localparam logic [IR_W-1:0] OP_IDENT = 5'b00001;

    typedef enum logic [1:0] {
        PATH_BYP = 2'd0,
        PATH_ID  = 2'd1,
        PATH_CTL = 2'd2
    } dr_path_e;

    typedef struct packed {
        logic tlr;
        logic cap;
        logic shf;
        logic upd;
    } tap_strb_t;

    function automatic dr_path_e pick_path(input logic [IR_W-1:0] op,
                                           input logic [IR_W-1:0] ctl_op);
        if (op == OP_IDENT) return PATH_ID;
        if (op == ctl_op)   return PATH_CTL;
        return PATH_BYP;
    endfunction

    function automatic logic [ID_W-1:0] pack_id(input logic [REV_W-1:0]  rev,
                                                input logic [DSG_W-1:0]  dsg,
                                                input logic [PART_W-1:0] part,
                                                input logic [MAKR_W-1:0] makr);
        return {rev, dsg, part, makr, 1'b1};
    endfunction

endpackage

// File: rtl/dr_bypass_stage.sv
module dr_bypass_stage (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic cap,
    input  logic shf,
    input  logic tdi,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (sel && cap)
            q <= 1'b0;
        else if (sel && shf)
            q <= tdi;
    end
endmodule

// File: rtl/dr_ident_stage.sv
module dr_ident_stage #(
    parameter int                W       = 32,
    parameter logic [W-1:0]      ID_WORD = '1
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic cap,
    input  logic shf,
    input  logic tdi,
    output logic so
);
    logic [W-1:0] sreg_q;

    always_ff @(posedge clk) begin
        if (rst)
            sreg_q <= ID_WORD;
        else if (sel && cap)
            sreg_q <= ID_WORD;
        else if (sel && shf)
            sreg_q <= {tdi, sreg_q[W-1:1]};
    end

    assign so = sreg_q[0];
endmodule

// File: rtl/dr_ctrl_stage.sv
module dr_ctrl_stage #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic         shf,
    input  logic         upd,
    input  logic         tdi,
    output logic         so,
    output logic [W-1:0] shift_q,
    output logic [W-1:0] hold_q
);
    always_ff @(posedge clk) begin
        if (rst)
            shift_q <= '0;
        else if (sel && shf)
            shift_q <= {tdi, shift_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (sel && upd)
            hold_q <= shift_q;
    end

    assign so = shift_q[0];
endmodule

// File: rtl/tap_dr_path.sv
module tap_dr_path
    import tap_dr_pkg::*;
#(
    parameter logic [IR_W-1:0]   CTL_OP  = 5'b01100,
    parameter int                CTL_W   = 64,
    parameter logic [REV_W-1:0]  ID_REV  = 4'h0,
    parameter logic [DSG_W-1:0]  ID_DSG  = 6'h20,
    parameter logic [PART_W-1:0] ID_PART = 10'h274,
    parameter logic [MAKR_W-1:0] ID_MAKR = 11'h00E
) (
    input  logic             tck,
    input  logic             tap_rst,
    input  logic             tlr,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic [IR_W-1:0]  ir_code,
    input  logic             tdi,
    output logic             dr_tdo,
    output logic [CTL_W-1:0] ctrl_word
);
    localparam logic [ID_W-1:0] ID_WORD = pack_id(ID_REV, ID_DSG, ID_PART, ID_MAKR);

    tap_strb_t  strb;
    dr_path_e   path;
    logic       rst_any;
    logic       byp_so, id_so, ctl_so;
    logic [CTL_W-1:0] ctl_shift_w;

    assign strb    = '{tlr: tlr, cap: capture_dr, shf: shift_dr, upd: update_dr};
    assign path    = pick_path(ir_code, CTL_OP);
    assign rst_any = tap_rst | strb.tlr;

    dr_bypass_stage u_byp (
        .clk (tck),
        .rst (rst_any),
        .sel (path == PATH_BYP),
        .cap (strb.cap),
        .shf (strb.shf),
        .tdi (tdi),
        .q   (byp_so)
    );

    dr_ident_stage #(
        .W       (ID_W),
        .ID_WORD (ID_WORD)
    ) u_id (
        .clk (tck),
        .rst (rst_any),
        .sel (path == PATH_ID),
        .cap (strb.cap),
        .shf (strb.shf),
        .tdi (tdi),
        .so  (id_so)
    );

    dr_ctrl_stage #(
        .W (CTL_W)
    ) u_ctl (
        .clk     (tck),
        .rst     (rst_any),
        .sel     (path == PATH_CTL),
        .shf     (strb.shf),
        .upd     (strb.upd),
        .tdi     (tdi),
        .so      (ctl_so),
        .shift_q (ctl_shift_w),
        .hold_q  (ctrl_word)
    );

    always_comb begin
        unique case (path)
            PATH_ID:  dr_tdo = id_so;
            PATH_CTL: dr_tdo = ctl_so;
            default:  dr_tdo = byp_so;
        endcase
    end
endmodule

// File: rtl/tap_dr_path_chk.sv
module tap_dr_path_chk
    import tap_dr_pkg::*;
#(
    parameter logic [IR_W-1:0] CTL_OP = 5'b01100,
    parameter int              CTL_W  = 64
) (
    input logic             tck,
    input logic             tap_rst,
    input logic             tlr,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic [IR_W-1:0]  ir_code,
    input logic             tdi,
    input logic             dr_tdo,
    input logic [CTL_W-1:0] ctrl_word,
    input logic [CTL_W-1:0] ctl_shift
);
    logic is_byp, is_id, is_ctl;
    assign is_byp = (pick_path(ir_code, CTL_OP) == PATH_BYP);
    assign is_id  = (pick_path(ir_code, CTL_OP) == PATH_ID);
    assign is_ctl = (pick_path(ir_code, CTL_OP) == PATH_CTL);

    a_r2_bypass_first_zero: assert property (@(posedge tck) disable iff (tap_rst)
        (capture_dr && !tlr && is_byp) ##1 is_byp |-> !dr_tdo);

    a_r3_bypass_delay: assert property (@(posedge tck) disable iff (tap_rst)
        (shift_dr && !capture_dr && !tlr && is_byp) ##1 is_byp |-> dr_tdo == $past(tdi));

    a_r4_ident_first_one: assert property (@(posedge tck) disable iff (tap_rst)
        (capture_dr && !tlr && is_id) ##1 is_id |-> dr_tdo);

    a_r5_update_other_keeps: assert property (@(posedge tck) disable iff (tap_rst)
        (update_dr && !tlr && !is_ctl) |=> $stable(ctrl_word));

    a_r6_update_copies: assert property (@(posedge tck) disable iff (tap_rst)
        (update_dr && !tlr && is_ctl) |=> ctrl_word == $past(ctl_shift));

    a_r7_hold_stable: assert property (@(posedge tck) disable iff (tap_rst)
        (!update_dr && !tlr) |=> $stable(ctrl_word));

    a_r8_capture_keeps_shift: assert property (@(posedge tck) disable iff (tap_rst)
        (capture_dr && !shift_dr && !tlr && is_ctl) |=> ctl_shift == $past(ctl_shift));

    a_r9_tlr_clears: assert property (@(posedge tck) disable iff (tap_rst)
        tlr |=> (ctrl_word == '0) && (ctl_shift == '0));
endmodule

bind tap_dr_path tap_dr_path_chk #(
    .CTL_OP (CTL_OP),
    .CTL_W  (CTL_W)
) u_chk (
    .tck        (tck),
    .tap_rst    (tap_rst),
    .tlr        (tlr),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .ir_code    (ir_code),
    .tdi        (tdi),
    .dr_tdo     (dr_tdo),
    .ctrl_word  (ctrl_word),
    .ctl_shift  (ctl_shift_w)
);

// File: tb/tap_dr_path_tb_top.sv
`timescale 1ns/1ps
module tap_dr_path_tb_top;

    localparam logic [4:0]  OP_CTL  = 5'b01100;
    localparam logic [4:0]  OP_ID   = 5'b00001;
    localparam logic [4:0]  OP_BYP  = 5'b11111;
    localparam logic [4:0]  OP_RSV  = 5'b10101;
    localparam logic [31:0] ID_EXP  = 32'h0827401D;
    localparam logic [63:0] VEC_A   = 64'hA5C3_0F96_1E2D_7B48;
    localparam logic [63:0] VEC_B   = 64'h3C71_E8D2_94B6_05FA;

    logic        tck = 1'b0;
    logic        tap_rst, tlr, capture_dr, shift_dr, update_dr, tdi;
    logic [4:0]  ir_code;
    logic        dr_tdo;
    logic [63:0] ctrl_word;

    always #10 tck = ~tck;

    tap_dr_path dut_i (
        .tck        (tck),
        .tap_rst    (tap_rst),
        .tlr        (tlr),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .ir_code    (ir_code),
        .tdi        (tdi),
        .dr_tdo     (dr_tdo),
        .ctrl_word  (ctrl_word)
    );

    int n_run  = 0;
    int n_fail = 0;

    typedef struct {
        logic  bitv;
        string req;
    } exp_t;
    exp_t sb_q[$];
    exp_t cur;

    // monitor: compares dr_tdo against the scoreboard queue away from the edge
    always @(negedge tck) begin
        #2;
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            n_run++;
            if (dr_tdo !== cur.bitv) begin
                n_fail++;
                $display("FAIL %s: dr_tdo=%0b expected %0b", cur.req, dr_tdo, cur.bitv);
            end
        end
    end

    task automatic push(input logic e, input string r);
        exp_t it;
        it.bitv = e;
        it.req  = r;
        sb_q.push_back(it);
    endtask

    task automatic cyc(input logic c, input logic s, input logic u,
                       input logic t, input logic d);
        @(negedge tck);
        capture_dr = c;
        shift_dr   = s;
        update_dr  = u;
        tlr        = t;
        tdi        = d;
    endtask

    task automatic chk_word(input logic [63:0] exp, input string r);
        @(negedge tck);
        capture_dr = 0; shift_dr = 0; update_dr = 0; tlr = 0;
        #3;
        n_run++;
        if (ctrl_word !== exp) begin
            n_fail++;
            $display("FAIL %s: ctrl_word=%h expected %h", r, ctrl_word, exp);
        end
    endtask

    task automatic bypass_run(input logic [4:0] op, input string r);
        logic [7:0] pat = 8'b1011_0010;
        ir_code = op;
        cyc(0, 1, 0, 0, 1'b1);       // put a 1 in the stage first
        cyc(1, 0, 0, 0, 1'b0);       // capture clears it
        for (int k = 0; k < 8; k++) begin
            cyc(0, 1, 0, 0, pat[k]);
            push(k == 0 ? 1'b0 : pat[k-1], k == 0 ? {r, "/R2"} : {r, "/R3"});
        end
    endtask

    task automatic ident_run(input string r);
        ir_code = OP_ID;
        cyc(1, 0, 0, 0, 1'b0);
        for (int k = 0; k < 32; k++) begin
            cyc(0, 1, 0, 0, 1'b0);
            push(ID_EXP[k], r);
        end
    endtask

    task automatic ctl_load(input logic [63:0] v);
        ir_code = OP_CTL;
        for (int k = 0; k < 64; k++) cyc(0, 1, 0, 0, v[k]);
    endtask

    initial begin
        tap_rst = 1; tlr = 0; capture_dr = 0; shift_dr = 0; update_dr = 0;
        tdi = 0; ir_code = OP_BYP;
        repeat (3) @(negedge tck);
        tap_rst = 0;

        chk_word(64'h0, "R9 reset value");

        // R2 R3: bypass delay and capture clear
        bypass_run(OP_BYP, "R1 bypass code");

        // R6: control load, R7 hold stable during shift
        ctl_load(VEC_A);
        chk_word(64'h0, "R7 no change while shifting");
        ir_code = OP_CTL;
        cyc(0, 0, 1, 0, 1'b0);
        chk_word(VEC_A, "R6 update copies");

        // R8: capture keeps shift stage, re-shift shows VEC_A
        ir_code = OP_CTL;
        cyc(1, 0, 0, 0, 1'b0);
        for (int k = 0; k < 64; k++) begin
            cyc(0, 1, 0, 0, VEC_B[k]);
            push(VEC_A[k], "R8 capture keeps control shift");
        end
        chk_word(VEC_A, "R7 hold after capture and shift");

        // R4 identification word, R5 update under ident
        ident_run("R4 ident word");
        ir_code = OP_ID;
        cyc(0, 0, 1, 0, 1'b0);
        chk_word(VEC_A, "R5 update under ident");
        ident_run("R5 ident reload");

        // R1 reserved code uses bypass; R5 update under bypass
        bypass_run(OP_RSV, "R1 reserved code");
        ir_code = OP_RSV;
        cyc(0, 0, 1, 0, 1'b0);
        chk_word(VEC_A, "R5 update under bypass");

        // R6 second word (VEC_B already in shift stage)
        ir_code = OP_CTL;
        cyc(0, 0, 1, 0, 1'b0);
        chk_word(VEC_B, "R6 second update");

        // R9 test-logic-reset strobe clears
        cyc(0, 0, 0, 1, 1'b0);
        chk_word(64'h0, "R9 tlr clears hold");
        ir_code = OP_CTL;
        cyc(0, 1, 0, 0, 1'b0);
        push(1'b0, "R9 tlr clears shift");

        // R9 tap_rst clears
        ctl_load(VEC_B);
        cyc(0, 0, 1, 0, 1'b0);
        chk_word(VEC_B, "R6 third update");
        @(negedge tck); tap_rst = 1;
        @(negedge tck); tap_rst = 0;
        chk_word(64'h0, "R9 tap_rst clears hold");

        repeat (3) @(negedge tck);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule